// File: doc/BRIEF.md
# Dual-Port Burst-Counter Synchronous RAM

A synchronous static memory with two fully independent ports that can each read or write any word. Both ports may use the same word in the same cycle. Each port has its own clock. On the rising edge of that clock the port registers its controls, its write data and its address request. The word is 18 bits wide and is split into two 9-bit lanes. A per-lane enable selects which lanes a write changes and which lanes a read presents. Read data reaches the pins through an output register, one cycle after the access is registered.

Each port keeps an internal burst address counter, and this counter is the address the access uses. On a clock edge the counter does one of four things: it clears to zero, loads the external address, steps by one (wrapping at the top of the array), or holds its value. The clear has the highest priority and the step the lowest. The counter acts whether or not the port is selected, so long bursts run without a fresh address in each cycle. An access happens only when the active-low select and the active-high select are both asserted, which allows depth expansion. An output enable gates the registered read data without waiting for a clock edge. If both ports write the same word on the same edge, the stored value is undefined.

The array depth is `2**ADDR_W` words. The default is 1024 words, and `ADDR_W = 15` gives the full 32768-word array.

Top module: `dpbc_ram`

## Requirements
- R1: After reset, each port's `rvld` is 0 and its `rdata` is 0, and its internal address is 0. The memory contents survive reset.
- R2: A read captured on edge N shows its word on `rdata` after edge N+1, and shows it only then. A write or idle cycle leaves `rvld` at 0 one edge later.
- R3: `lane_en[0]` selects bits 8:0 and `lane_en[1]` selects bits 17:9. A write changes only the enabled lanes. A read asserts `rvld` only for enabled lanes, and drives 0 on the other lanes.
- R4: With `cnt_clr` low and `strobe` high, the access uses `addr`, and the counter takes that value.
- R5: With `cnt_clr` and `strobe` low and `cnt_en` high, the access uses the previous internal address plus one. The address after 2**ADDR_W-1 is 0.
- R6: With `cnt_clr`, `strobe` and `cnt_en` all low, the access reuses the previous internal address.
- R7: `cnt_clr` makes the access use address 0 whatever the other inputs are. `strobe` takes priority over `cnt_en`.
- R8: The port makes an access only when `sel_n` is 0 and `sel` is 1. A deselected cycle writes nothing and yields `rvld` = 0, but the counter still follows R4 to R7.
- R9: `oe` low forces `rvld` and `rdata` to 0 at once, without a clock edge. Raising `oe` again shows the held read data at once.
- R10: A word written by one port can be read by the other port. Both ports can read the same word in the same cycle, and both can write different words in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both ports' registers |
| a_clk | input | 1 | Port A clock |
| a_sel_n | input | 1 | Port A select, active low |
| a_sel | input | 1 | Port A select, active high |
| a_wr | input | 1 | Port A write (1) or read (0) |
| a_lane_en | input | 2 | Port A lane enables (bit 0: bits 8:0, bit 1: bits 17:9) |
| a_oe | input | 1 | Port A output enable, asynchronous |
| a_strobe | input | 1 | Port A load external address |
| a_cnt_en | input | 1 | Port A counter step enable |
| a_cnt_clr | input | 1 | Port A counter clear |
| a_addr | input | ADDR_W | Port A external address |
| a_wdata | input | 18 | Port A write data |
| a_rdata | output | 18 | Port A read data, 0 on lanes that are not valid |
| a_rvld | output | 2 | Port A per-lane read-data valid |
| b_clk | input | 1 | Port B clock |
| b_sel_n | input | 1 | Port B select, active low |
| b_sel | input | 1 | Port B select, active high |
| b_wr | input | 1 | Port B write (1) or read (0) |
| b_lane_en | input | 2 | Port B lane enables |
| b_oe | input | 1 | Port B output enable, asynchronous |
| b_strobe | input | 1 | Port B load external address |
| b_cnt_en | input | 1 | Port B counter step enable |
| b_cnt_clr | input | 1 | Port B counter clear |
| b_addr | input | ADDR_W | Port B external address |
| b_wdata | input | 18 | Port B write data |
| b_rdata | output | 18 | Port B read data |
| b_rvld | output | 2 | Port B per-lane read-data valid |

## Verification
The internal address cannot be seen at the pins, so the hardest cases are the counter priorities and a counter that keeps moving while the port is deselected. The stimulus writes a marker word in a cycle where clear, strobe and step are all raised together. It then reads the marker back through an explicitly strobed address, so the location that took the write shows which control won. In the same way, a deselected write that still steps the counter is followed by a holding read: the holding read shows both that the old word is intact and that the address moved.

// File: rtl/dpbc_pkg.sv
package dpbc_pkg;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_STEP = 2'd1,
        CNT_LOAD = 2'd2,
        CNT_ZERO = 2'd3
    } cnt_op_e;

    // Clear beats load, load beats step.
    function automatic cnt_op_e pick_op(input logic clr, input logic load, input logic step);
        cnt_op_e op;
        if (clr)       op = CNT_ZERO;
        else if (load) op = CNT_LOAD;
        else if (step) op = CNT_STEP;
        else           op = CNT_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/dpbc_addr_ctr.sv
module dpbc_addr_ctr
    import dpbc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ctr_t;

    ctr_t    c_d, c_q;
    cnt_op_e op;

    always_comb begin
        op  = pick_op(clr, load, step);
        c_d = c_q;
        case (op)
            CNT_ZERO: c_d.addr = '0;
            CNT_LOAD: c_d.addr = ext_addr;
            CNT_STEP: c_d.addr = c_q.addr + ADDR_W'(1);
            default:  c_d.addr = c_q.addr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign addr_q = c_q.addr;

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (addr_q == '0));
    a_r4_load_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load) |=> (addr_q == $past(ext_addr)));
    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && step) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
    a_r6_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && !step) |=> $stable(addr_q));

endmodule

// File: rtl/dpbc_bank.sv
module dpbc_bank #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [WORD_W-1:0] rdata_a,
    output logic [WORD_W-1:0] rdata_b
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata_a[g*LANE_W +: LANE_W] = mem[raddr_a];
        assign rdata_b[g*LANE_W +: LANE_W] = mem[raddr_b];
    end

endmodule

// File: rtl/dpbc_port.sv
module dpbc_port #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [LANES-1:0]  lane_en,
    input  logic              oe,
    input  logic              strobe,
    input  logic              cnt_en,
    input  logic              cnt_clr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  wr_lanes,
    output logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rdata,
    output logic [LANES-1:0]  rvld
);

    typedef struct packed {
        logic [LANES-1:0]  wr_lanes;
        logic [LANES-1:0]  rd_lanes;
        logic [WORD_W-1:0] wdata;
        logic [LANES-1:0]  out_lanes;
        logic [WORD_W-1:0] out_data;
    } stage_t;

    stage_t s_d, s_q;
    logic   sel_ok;

    dpbc_addr_ctr #(.ADDR_W(ADDR_W)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .load     (strobe),
        .step     (cnt_en),
        .ext_addr (addr),
        .addr_q   (acc_addr)
    );

    always_comb begin
        sel_ok      = !sel_n && sel;
        s_d         = s_q;
        s_d.wr_lanes = (sel_ok && wr)  ? lane_en : '0;
        s_d.rd_lanes = (sel_ok && !wr) ? lane_en : '0;
        s_d.wdata    = (sel_ok && wr)  ? wdata   : s_q.wdata;
        s_d.out_lanes = s_q.rd_lanes;
        for (int l = 0; l < LANES; l++) begin
            s_d.out_data[l*LANE_W +: LANE_W] =
                s_q.rd_lanes[l] ? rd_word[l*LANE_W +: LANE_W] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_lanes = s_q.wr_lanes;
    assign wr_word  = s_q.wdata;
    assign rvld     = oe ? s_q.out_lanes : '0;

    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign rdata[g*LANE_W +: LANE_W] = rvld[g] ? s_q.out_data[g*LANE_W +: LANE_W] : '0;
    end

    a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ok && !wr) |=> ##1 (s_q.out_lanes == $past(lane_en, 2)));
    a_r2_write_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ok && wr) |=> ##1 (s_q.out_lanes == '0));
    a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok) |=> ##1 (s_q.out_lanes == '0));
    a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok) |=> (wr_lanes == '0));

endmodule

// File: rtl/dpbc_ram.sv
module dpbc_ram #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              rst_n,
    input  logic              a_clk,
    input  logic              a_sel_n,
    input  logic              a_sel,
    input  logic              a_wr,
    input  logic [LANES-1:0]  a_lane_en,
    input  logic              a_oe,
    input  logic              a_strobe,
    input  logic              a_cnt_en,
    input  logic              a_cnt_clr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WORD_W-1:0] a_wdata,
    output logic [WORD_W-1:0] a_rdata,
    output logic [LANES-1:0]  a_rvld,
    input  logic              b_clk,
    input  logic              b_sel_n,
    input  logic              b_sel,
    input  logic              b_wr,
    input  logic [LANES-1:0]  b_lane_en,
    input  logic              b_oe,
    input  logic              b_strobe,
    input  logic              b_cnt_en,
    input  logic              b_cnt_clr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [WORD_W-1:0] b_wdata,
    output logic [WORD_W-1:0] b_rdata,
    output logic [LANES-1:0]  b_rvld
);

    // Bank A is written only by port A, bank B only by port B.
    // A word's value is the XOR of both banks at that address.
    logic [ADDR_W-1:0] a_acc, b_acc;
    logic [LANES-1:0]  a_wl, b_wl;
    logic [WORD_W-1:0] a_ww, b_ww;
    logic [WORD_W-1:0] ka_at_a, ka_at_b, kb_at_a, kb_at_b;
    logic [WORD_W-1:0] a_word, b_word;

    assign a_word = ka_at_a ^ kb_at_a;
    assign b_word = ka_at_b ^ kb_at_b;

    dpbc_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) port_a_i (
        .clk (a_clk), .rst_n (rst_n), .sel_n (a_sel_n), .sel (a_sel), .wr (a_wr),
        .lane_en (a_lane_en), .oe (a_oe), .strobe (a_strobe), .cnt_en (a_cnt_en),
        .cnt_clr (a_cnt_clr), .addr (a_addr), .wdata (a_wdata), .rd_word (a_word),
        .acc_addr (a_acc), .wr_lanes (a_wl), .wr_word (a_ww),
        .rdata (a_rdata), .rvld (a_rvld)
    );

    dpbc_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) port_b_i (
        .clk (b_clk), .rst_n (rst_n), .sel_n (b_sel_n), .sel (b_sel), .wr (b_wr),
        .lane_en (b_lane_en), .oe (b_oe), .strobe (b_strobe), .cnt_en (b_cnt_en),
        .cnt_clr (b_cnt_clr), .addr (b_addr), .wdata (b_wdata), .rd_word (b_word),
        .acc_addr (b_acc), .wr_lanes (b_wl), .wr_word (b_ww),
        .rdata (b_rdata), .rvld (b_rvld)
    );

    dpbc_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) bank_a_i (
        .clk (a_clk), .we (a_wl), .waddr (a_acc), .wdata (a_ww ^ kb_at_a),
        .raddr_a (a_acc), .raddr_b (b_acc), .rdata_a (ka_at_a), .rdata_b (ka_at_b)
    );

    dpbc_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) bank_b_i (
        .clk (b_clk), .we (b_wl), .waddr (b_acc), .wdata (b_ww ^ ka_at_b),
        .raddr_a (a_acc), .raddr_b (b_acc), .rdata_a (kb_at_a), .rdata_b (kb_at_b)
    );

    a_r9_a_oe_gate: assert property (@(posedge a_clk) disable iff (!rst_n)
        !a_oe |-> (a_rvld == '0 && a_rdata == '0));
    a_r9_b_oe_gate: assert property (@(posedge b_clk) disable iff (!rst_n)
        !b_oe |-> (b_rvld == '0 && b_rdata == '0));

endmodule

// File: tb/dpbc_ram_tb.sv
`timescale 1ns/1ps
module dpbc_ram_tb_top;

    localparam int AW = 10;
    localparam int NV = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          a_sel_n, a_sel, a_wr, a_oe, a_strobe, a_cnt_en, a_cnt_clr;
    logic [1:0]    a_lane_en, a_rvld;
    logic [AW-1:0] a_addr;
    logic [17:0]   a_wdata, a_rdata;
    logic          b_sel_n, b_sel, b_wr, b_oe, b_strobe, b_cnt_en, b_cnt_clr;
    logic [1:0]    b_lane_en, b_rvld;
    logic [AW-1:0] b_addr;
    logic [17:0]   b_wdata, b_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    dpbc_ram #(.ADDR_W(AW)) dut_i (
        .rst_n (rst_n),
        .a_clk (clk), .a_sel_n (a_sel_n), .a_sel (a_sel), .a_wr (a_wr),
        .a_lane_en (a_lane_en), .a_oe (a_oe), .a_strobe (a_strobe),
        .a_cnt_en (a_cnt_en), .a_cnt_clr (a_cnt_clr), .a_addr (a_addr),
        .a_wdata (a_wdata), .a_rdata (a_rdata), .a_rvld (a_rvld),
        .b_clk (clk), .b_sel_n (b_sel_n), .b_sel (b_sel), .b_wr (b_wr),
        .b_lane_en (b_lane_en), .b_oe (b_oe), .b_strobe (b_strobe),
        .b_cnt_en (b_cnt_en), .b_cnt_clr (b_cnt_clr), .b_addr (b_addr),
        .b_wdata (b_wdata), .b_rdata (b_rdata), .b_rvld (b_rvld)
    );

    // sel field is {sel_n, sel}; 2'b01 selects the port.
    typedef struct packed {
        logic [3:0]  rq;
        logic        clr, stb, inc;
        logic [1:0]  sel;
        logic        wr;
        logic [1:0]  ln;
        logic [9:0]  ad;
        logic [17:0] wd;
        logic [1:0]  xv;
        logic [17:0] xd;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        // R4 strobe write to 5; R5 steps to 6 and 7
        '{4'd4, 1'b0, 1'b1, 1'b0, 2'b01, 1'b1, 2'b11, 10'd5, 18'h12345, 2'b00, 18'h0},
        '{4'd5, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 2'b11, 10'd0, 18'h0ABCD, 2'b00, 18'h0},
        '{4'd5, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 2'b11, 10'd0, 18'h3F00F, 2'b00, 18'h0},
        // R2 read back through strobe, step (R5) and hold (R6)
        '{4'd2, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b11, 10'd5, 18'h0, 2'b11, 18'h12345},
        '{4'd5, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 2'b11, 10'd0, 18'h0, 2'b11, 18'h0ABCD},
        '{4'd6, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 2'b11, 10'd0, 18'h0, 2'b11, 18'h0ABCD},
        '{4'd5, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 2'b11, 10'd0, 18'h0, 2'b11, 18'h3F00F},
        // R3 lower-lane write, then full, upper-only and lower-only reads
        '{4'd3, 1'b0, 1'b1, 1'b0, 2'b01, 1'b1, 2'b01, 10'd5, 18'h0, 2'b00, 18'h0},
        '{4'd3, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b11, 10'd5, 18'h0, 2'b11, 18'h12200},
        '{4'd3, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 2'b10, 10'd0, 18'h0, 2'b10, 18'h12200},
        '{4'd3, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 2'b01, 10'd0, 18'h0, 2'b01, 18'h001CD},
        // R8 write with sel_n high: no write, counter still steps to 7
        '{4'd8, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 2'b11, 10'd0, 18'h0, 2'b00, 18'h0},
        '{4'd8, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 2'b11, 10'd0, 18'h0, 2'b11, 18'h3F00F},
        // R7 clear beats strobe and step: write lands at 0
        '{4'd7, 1'b1, 1'b1, 1'b1, 2'b01, 1'b1, 2'b11, 10'd9, 18'h2AAAA, 2'b00, 18'h0},
        '{4'd7, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b11, 10'd0, 18'h0, 2'b11, 18'h2AAAA},
        // R5 wrap from the top address to 0
        '{4'd5, 1'b0, 1'b1, 1'b0, 2'b01, 1'b1, 2'b11, 10'h3FF, 18'h15555, 2'b00, 18'h0},
        '{4'd5, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 2'b11, 10'd0, 18'h0, 2'b11, 18'h2AAAA},
        // R7 strobe beats step
        '{4'd7, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 2'b11, 10'd6, 18'h0, 2'b11, 18'h0ABCD},
        // R8 write with sel low is dropped
        '{4'd8, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b11, 10'd0, 18'h0, 2'b00, 18'h0},
        '{4'd8, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 2'b11, 10'd0, 18'h0, 2'b11, 18'h0ABCD}
    };

    task automatic chk(input string tag, input logic [1:0] gv, input logic [17:0] gd,
                       input logic [1:0] ev, input logic [17:0] ed);
        checks++;
        if (gv !== ev || gd !== ed) begin
            fails++;
            $display("FAIL %s: rvld=%b rdata=%h expected rvld=%b rdata=%h", tag, gv, gd, ev, ed);
        end
    endtask

    task automatic drv_a(input logic clr, stb, inc, input logic [1:0] sel, input logic wr,
                         input logic [1:0] ln, input logic [AW-1:0] ad, input logic [17:0] wd);
        a_cnt_clr = clr; a_strobe = stb; a_cnt_en = inc;
        a_sel_n = sel[1]; a_sel = sel[0]; a_wr = wr;
        a_lane_en = ln; a_addr = ad; a_wdata = wd;
    endtask

    task automatic drv_b(input logic clr, stb, inc, input logic [1:0] sel, input logic wr,
                         input logic [1:0] ln, input logic [AW-1:0] ad, input logic [17:0] wd);
        b_cnt_clr = clr; b_strobe = stb; b_cnt_en = inc;
        b_sel_n = sel[1]; b_sel = sel[0]; b_wr = wr;
        b_lane_en = ln; b_addr = ad; b_wdata = wd;
    endtask

    task automatic idle_a();
        drv_a(1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 2'b00, '0, '0);
    endtask

    task automatic idle_b();
        drv_b(1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 2'b00, '0, '0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        a_oe = 1'b1; b_oe = 1'b1;
        idle_a(); idle_b();
        repeat (3) @(negedge clk);
        // R1 outputs cleared in reset
        chk("R1 in reset", a_rvld, a_rdata, 2'b00, 18'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset port A", a_rvld, a_rdata, 2'b00, 18'h0);
        chk("R1 after reset port B", b_rvld, b_rdata, 2'b00, 18'h0);

        // vector table on port A
        for (int j = 0; j < NV + 2; j++) begin
            @(negedge clk);
            if (j >= 2) begin
                vec_t pv;
                pv = VEC[j-2];
                chk($sformatf("R%0d vector %0d", pv.rq, j - 2), a_rvld, a_rdata, pv.xv, pv.xd);
            end
            if (j < NV) drv_a(VEC[j].clr, VEC[j].stb, VEC[j].inc, VEC[j].sel, VEC[j].wr,
                              VEC[j].ln, VEC[j].ad, VEC[j].wd);
            else idle_a();
        end

        // R9 asynchronous output enable
        drv_a(1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b11, 10'd5, '0);
        @(negedge clk); idle_a();
        @(negedge clk);
        a_oe = 1'b0; #1;
        chk("R9 oe low hides data", a_rvld, a_rdata, 2'b00, 18'h0);
        a_oe = 1'b1; #1;
        chk("R9 oe high shows held data", a_rvld, a_rdata, 2'b11, 18'h12200);

        // R1 second reset: address back to 0, memory kept
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears outputs", a_rvld, a_rdata, 2'b00, 18'h0);
        rst_n = 1'b1;
        drv_a(1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 2'b11, '0, '0);
        @(negedge clk); idle_a();
        @(negedge clk);
        chk("R1 counter at 0 after reset", a_rvld, a_rdata, 2'b11, 18'h2AAAA);

        // R10 simultaneous writes to different words, cross reads
        drv_a(1'b0, 1'b1, 1'b0, 2'b01, 1'b1, 2'b11, 10'd20, 18'h0F0F0);
        drv_b(1'b0, 1'b1, 1'b0, 2'b01, 1'b1, 2'b11, 10'd21, 18'h30303);
        @(negedge clk);
        drv_a(1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b11, 10'd21, '0);
        drv_b(1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b11, 10'd20, '0);
        @(negedge clk);
        drv_a(1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b11, 10'd20, '0);
        drv_b(1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b11, 10'd20, '0);
        @(negedge clk);
        chk("R10 port A reads port B write", a_rvld, a_rdata, 2'b11, 18'h30303);
        chk("R10 port B reads port A write", b_rvld, b_rdata, 2'b11, 18'h0F0F0);
        idle_a(); idle_b();
        @(negedge clk);
        chk("R10 same word port A", a_rvld, a_rdata, 2'b11, 18'h0F0F0);
        chk("R10 same word port B", b_rvld, b_rdata, 2'b11, 18'h0F0F0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule